// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block drives a raw 8-bit NAND flash bus (chip enables, command latch, address latch, write and read strobes, ready/busy and data) from a small set of 16-bit registers. Software loads a command byte or an address byte into a holding register and then writes a trigger word whose low six bits name one bus operation. The engine waits until the flash reports ready, performs that single operation with fixed strobe timing, and then raises a sticky completion flag that can also drive an interrupt line.

Page transfers move a whole page plus its spare area between the flash and an internal byte buffer. Identification and status reads capture their bytes at the start of that buffer. The host reaches the buffer through a separate byte port. A multi-step flash command, such as a page read with its confirm byte (0x30 on large-page parts), is built by software from a chain of single triggers: command, column and row address bytes (row least significant first), the confirm command, then the data transfer.

Top module: `nand_op_seq`

## Requirements
- R1: After reset the control register (index 2) reads 0x0000, the configuration register (index 3) reads 0x0010, the buffer-select register (index 4) reads 0x0000, all chip enables are high, both strobes are high and the interrupt is low.
- R2: A write to the control register starts one operation chosen by the lowest set bit among bits 5:0: bit0 command, bit1 address, bit2 page program (buffer to flash), bit3 page read (flash to buffer), bit4 ID read, bit5 status read. Bits 5:0 always read back as 0.
- R3: A command cycle puts the low byte of the command register (index 0) on the bus with the command latch high, and an address cycle puts the low byte of the address register (index 1) with the address latch high, each with one write-strobe pulse of T_LOW low cycles then T_HIGH high cycles.
- R4: Bit 15 of the control register is set when an operation finishes and stays set until a control write with bit 15 at 0; a write with bit 15 at 1 leaves it alone.
- R5: The interrupt output is high exactly when the completion flag is set and configuration bit 4 (mask) is 0.
- R6: A trigger written while an operation is waiting or transferring is ignored.
- R7: No strobe of a new operation starts until the ready/busy input is high; the engine waits for it without software help.
- R8: A page program sends PAGE_BYTES+SPARE_BYTES bytes from buffer index 0 upward, one per write-strobe pulse.
- R9: A page read stores the bus byte present in the last low cycle of each read-strobe pulse into buffer index 0 upward, PAGE_BYTES+SPARE_BYTES bytes in all.
- R10: An ID read stores 6 bytes and a status read stores 1 byte from buffer index 0; page, ID and status operations clear buffer-select bits 2:0 to 0 while command and address cycles leave them.
- R11: Writing configuration bit 6 aborts any operation, clears the completion flag, reads back as 1 for exactly one cycle, ignores triggers during that cycle, and then clears itself.
- R12: When configuration bit 7 is 1, the chip enable numbered by buffer-select bits 6:5 is low and all others high; when it is 0 all are high.
- R13: The two strobes are never low together and the two latch enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| hb_we | input | 1 | Host buffer write strobe |
| hb_addr | input | $clog2(PAGE_BYTES+SPARE_BYTES) | Host buffer byte index |
| hb_wdata | input | 8 | Host buffer write byte |
| hb_rdata | output | 8 | Host buffer read byte |
| irq | output | 1 | Completion interrupt |
| nand_ce_n | output | 1<<CS_BITS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from flash |
| nand_dq_o | output | 8 | Data driven to flash (0 when not driving) |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_i | input | 8 | Data from flash |

## Verification
The bench chases the lowest-bit choice when a trigger carries two operation bits; a design that took the highest bit would run a page program instead of an address cycle and the per-cycle pin model would flag a wrong latch line and data. It holds ready/busy low across a trigger, where a design that ignored the pin would pulse the write strobe early, and it fires a second trigger in the middle of a page program, which a design without the idle guard would answer by restarting and emitting extra pulses. It also aborts a page read with the soft reset and writes a trigger in the very next cycle, so a design whose reset bit lingered or that accepted that trigger would show read strobes or a set completion flag afterwards; buffer contents after ID and status reads show whether bytes beyond the captured count were overwritten.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_WAIT = 2'd1,
        ENG_XFER = 2'd2
    } eng_state_e;

    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_ADDR = 3'd1,
        OP_PROG = 3'd2,
        OP_READ = 3'd3,
        OP_ID   = 3'd4,
        OP_STAT = 3'd5
    } op_kind_e;

    localparam int NUM_OPS = 6;

    localparam logic [2:0] REG_CMD  = 3'd0;
    localparam logic [2:0] REG_ADDR = 3'd1;
    localparam logic [2:0] REG_CTRL = 3'd2;
    localparam logic [2:0] REG_CFG  = 3'd3;
    localparam logic [2:0] REG_BSEL = 3'd4;

    localparam int CTRL_DONE_BIT = 15;
    localparam int CFG_MASK_BIT  = 4;
    localparam int CFG_SRST_BIT  = 6;
    localparam int CFG_CE_BIT    = 7;
    localparam int BSEL_CS_LSB   = 5;
    localparam int BSEL_BUF_W    = 3;

    localparam int ID_LEN   = 6;
    localparam int STAT_LEN = 1;

    function automatic logic op_drives_bus(op_kind_e k);
        return (k == OP_CMD) || (k == OP_ADDR) || (k == OP_PROG);
    endfunction
endpackage

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
    parameter int T_LOW  = 3,
    parameter int T_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic in_low,
    output logic low_last,
    output logic high_last
);
    localparam int PERIOD = T_LOW + T_HIGH;
    localparam int CW     = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == CW'(PERIOD - 1))
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign in_low    = run && (cnt_q < CW'(T_LOW));
    assign low_last  = run && (cnt_q == CW'(T_LOW - 1));
    assign high_last = run && (cnt_q == CW'(PERIOD - 1));
endmodule

// File: rtl/nand_seq_bufram.sv
module nand_seq_bufram #(
    parameter int DEPTH = 20,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int SPARE_BYTES = 4,
    parameter int T_LOW       = 3,
    parameter int T_HIGH      = 2,
    parameter int CS_BITS     = 2
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        reg_we,
    input  logic [2:0]                                  reg_addr,
    input  logic [15:0]                                 reg_wdata,
    output logic [15:0]                                 reg_rdata,
    input  logic                                        hb_we,
    input  logic [$clog2(PAGE_BYTES+SPARE_BYTES)-1:0]   hb_addr,
    input  logic [7:0]                                  hb_wdata,
    output logic [7:0]                                  hb_rdata,
    output logic                                        irq,
    output logic [(1<<CS_BITS)-1:0]                     nand_ce_n,
    output logic                                        nand_cle,
    output logic                                        nand_ale,
    output logic                                        nand_we_n,
    output logic                                        nand_re_n,
    input  logic                                        nand_rb_n,
    output logic [7:0]                                  nand_dq_o,
    output logic                                        nand_dq_oe,
    input  logic [7:0]                                  nand_dq_i
);
    localparam int XFER_LEN = PAGE_BYTES + SPARE_BYTES;
    localparam int AW       = $clog2(XFER_LEN);
    localparam int NCS      = 1 << CS_BITS;

    typedef struct packed {
        eng_state_e        st;
        op_kind_e          op;
        logic [AW-1:0]     idx;
        logic [AW-1:0]     last;
        logic              done;
        logic              srst;
        logic              irq_mask;
        logic              ce_en;
        logic [CS_BITS-1:0] cs;
        logic [BSEL_BUF_W-1:0] bsel;
        logic [15:0]       cmd;
        logic [15:0]       addr;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic       in_low, low_last, high_last;
    logic       cap_we, done_set, done_clr, abort, found;
    op_kind_e   pick;
    logic [7:0] ram_a;
    logic       ram_we;
    logic [AW-1:0] ram_waddr;
    logic [7:0] ram_wdata;

    nand_seq_timer #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (s_q.st == ENG_XFER),
        .in_low    (in_low),
        .low_last  (low_last),
        .high_last (high_last)
    );

    assign ram_we    = cap_we || hb_we;
    assign ram_waddr = cap_we ? s_q.idx : hb_addr;
    assign ram_wdata = cap_we ? nand_dq_i : hb_wdata;

    nand_seq_bufram #(.DEPTH(XFER_LEN), .AW(AW)) u_buf (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (s_q.idx),
        .rdata_a (ram_a),
        .raddr_b (hb_addr),
        .rdata_b (hb_rdata)
    );

    always_comb begin
        s_d      = s_q;
        cap_we   = 1'b0;
        done_set = 1'b0;
        done_clr = 1'b0;
        abort    = 1'b0;
        found    = 1'b0;
        pick     = OP_CMD;

        case (s_q.st)
            ENG_WAIT: if (nand_rb_n) s_d.st = ENG_XFER;
            ENG_XFER: begin
                cap_we = !op_drives_bus(s_q.op) && low_last;
                if (high_last) begin
                    if (s_q.idx == s_q.last) begin
                        s_d.st   = ENG_IDLE;
                        done_set = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: ;
        endcase

        s_d.srst = 1'b0;

        if (reg_we) begin
            case (reg_addr)
                REG_CMD:  s_d.cmd  = reg_wdata;
                REG_ADDR: s_d.addr = reg_wdata;
                REG_CTRL: begin
                    done_clr = !reg_wdata[CTRL_DONE_BIT];
                    for (int i = NUM_OPS - 1; i >= 0; i--) begin
                        if (reg_wdata[i]) begin
                            found = 1'b1;
                            pick  = op_kind_e'(3'(i));
                        end
                    end
                    if (found && s_q.st == ENG_IDLE && !s_q.srst) begin
                        s_d.st  = ENG_WAIT;
                        s_d.op  = pick;
                        s_d.idx = '0;
                        case (pick)
                            OP_PROG, OP_READ: s_d.last = AW'(XFER_LEN - 1);
                            OP_ID:            s_d.last = AW'(ID_LEN - 1);
                            OP_STAT:          s_d.last = AW'(STAT_LEN - 1);
                            default:          s_d.last = '0;
                        endcase
                        if (pick != OP_CMD && pick != OP_ADDR) s_d.bsel = '0;
                    end
                end
                REG_CFG: begin
                    s_d.irq_mask = reg_wdata[CFG_MASK_BIT];
                    s_d.ce_en    = reg_wdata[CFG_CE_BIT];
                    if (reg_wdata[CFG_SRST_BIT]) begin
                        s_d.st   = ENG_IDLE;
                        s_d.srst = 1'b1;
                        abort    = 1'b1;
                    end
                end
                REG_BSEL: begin
                    s_d.cs   = reg_wdata[BSEL_CS_LSB +: CS_BITS];
                    s_d.bsel = reg_wdata[BSEL_BUF_W-1:0];
                end
                default: ;
            endcase
        end

        s_d.done = !abort && ((s_q.done && !done_clr) || done_set);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= ENG_IDLE;
            s_q.op       <= OP_CMD;
            s_q.irq_mask <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    logic xfer, drive, sense;
    assign xfer  = (s_q.st == ENG_XFER);
    assign drive = xfer && op_drives_bus(s_q.op);
    assign sense = xfer && !op_drives_bus(s_q.op);

    assign nand_we_n  = !(drive && in_low);
    assign nand_re_n  = !(sense && in_low);
    assign nand_cle   = xfer && (s_q.op == OP_CMD);
    assign nand_ale   = xfer && (s_q.op == OP_ADDR);
    assign nand_dq_oe = drive;

    always_comb begin
        nand_dq_o = 8'h00;
        if (drive) begin
            case (s_q.op)
                OP_CMD:  nand_dq_o = s_q.cmd[7:0];
                OP_ADDR: nand_dq_o = s_q.addr[7:0];
                default: nand_dq_o = ram_a;
            endcase
        end
    end

    for (genvar g = 0; g < NCS; g++) begin : g_ce
        assign nand_ce_n[g] = !(s_q.ce_en && (s_q.cs == CS_BITS'(g)));
    end

    assign irq = s_q.done && !s_q.irq_mask;

    always_comb begin
        reg_rdata = 16'h0000;
        case (reg_addr)
            REG_CMD:  reg_rdata = s_q.cmd;
            REG_ADDR: reg_rdata = s_q.addr;
            REG_CTRL: reg_rdata[CTRL_DONE_BIT] = s_q.done;
            REG_CFG: begin
                reg_rdata[CFG_MASK_BIT] = s_q.irq_mask;
                reg_rdata[CFG_SRST_BIT] = s_q.srst;
                reg_rdata[CFG_CE_BIT]   = s_q.ce_en;
            end
            REG_BSEL: begin
                reg_rdata[BSEL_CS_LSB +: CS_BITS] = s_q.cs;
                reg_rdata[BSEL_BUF_W-1:0]         = s_q.bsel;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk
    import nand_seq_pkg::*;
#(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [2:0]     reg_addr,
    input logic           nand_we_n,
    input logic           nand_re_n,
    input logic           nand_cle,
    input logic           nand_ale,
    input logic           nand_dq_oe,
    input logic [NCS-1:0] nand_ce_n,
    input logic           nand_rb_n,
    input logic           irq,
    input logic           done_q,
    input eng_state_e     st_q
);
    p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_latch_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_ce_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));

    p_irq_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_q);

    p_done_clear_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_q) && !done_q) |->
            $past(reg_we && (reg_addr == REG_CTRL || reg_addr == REG_CFG)));

    p_ready_before_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENG_XFER && $past(st_q) == ENG_WAIT) |-> $past(nand_rb_n));

    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENG_XFER) |=> (st_q != ENG_WAIT));

    p_cle_drives_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nand_cle |-> nand_dq_oe);
endmodule

bind nand_op_seq nand_op_seq_chk #(.NCS(1 << CS_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_dq_oe (nand_dq_oe),
    .nand_ce_n  (nand_ce_n),
    .nand_rb_n  (nand_rb_n),
    .irq        (irq),
    .done_q     (s_q.done),
    .st_q       (s_q.st)
);

// File: tb/sim_nand_op_seq.sv
`timescale 1ns/1ps
module sim_nand_op_seq;
    localparam int TL = 3, TH = 2, P = TL + TH, LEN = 20, AW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        reg_we = 0;
    logic [2:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic        hb_we = 0;
    logic [AW-1:0] hb_addr = 0;
    logic [7:0]  hb_wdata = 0, hb_rdata;
    logic        irq, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [3:0]  nand_ce_n;
    logic        nand_rb_n = 1'b1;
    logic [7:0]  nand_dq_o, nand_dq_i;

    int checks = 0, fails = 0, cyc = 0;
    int rd_cnt = 0, we_cnt = 0, rd_seed = 0;

    function automatic logic [7:0] fb(int seed, int k);
        return 8'((seed * 37 + k * 11 + 90) & 255);
    endfunction

    assign nand_dq_i = fb(rd_seed, rd_cnt);
    always @(posedge nand_re_n) rd_cnt++;
    always @(posedge nand_we_n) we_cnt++;

    nand_op_seq u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_st, m_op, m_t, m_n, m_cs, m_bsel;
    bit m_done, m_mask, m_ce, m_rstp;
    logic [15:0] m_cmd, m_addr;
    logic [7:0] mem_m [LEN];
    int st0, pk; bit set_f, clr_f, abort_f, rstp0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_op = 0; m_t = 0; m_n = 1; m_cs = 0; m_bsel = 0;
            m_done = 0; m_mask = 1; m_ce = 0; m_rstp = 0; m_cmd = 0; m_addr = 0;
        end else begin
            st0 = m_st; rstp0 = m_rstp; set_f = 0; clr_f = 0; abort_f = 0;
            if (m_st == 1) begin
                if (nand_rb_n) begin m_st = 2; m_t = 0; end
            end else if (m_st == 2) begin
                if (m_op >= 3 && (m_t % P) == TL - 1) mem_m[m_t / P] = fb(rd_seed, m_t / P);
                if (m_t == m_n * P - 1) begin m_st = 0; set_f = 1; end
                else m_t++;
            end
            m_rstp = 0;
            if (hb_we) mem_m[hb_addr] = hb_wdata;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_cmd = reg_wdata;
                    3'd1: m_addr = reg_wdata;
                    3'd2: begin
                        clr_f = !reg_wdata[15];
                        if (st0 == 0 && !rstp0 && reg_wdata[5:0] != 0) begin
                            pk = 0;
                            while (!reg_wdata[pk]) pk++;
                            m_op = pk; m_st = 1;
                            m_n = (pk == 2 || pk == 3) ? LEN : (pk == 4) ? 6 : 1;
                            if (pk >= 2) m_bsel = 0;
                        end
                    end
                    3'd3: begin
                        m_mask = reg_wdata[4]; m_ce = reg_wdata[7];
                        if (reg_wdata[6]) begin m_st = 0; m_rstp = 1; abort_f = 1; end
                    end
                    3'd4: begin m_cs = reg_wdata[6:5]; m_bsel = reg_wdata[2:0]; end
                    default: ;
                endcase
            end
            m_done = !abort_f && ((m_done && !clr_f) || set_f);
        end
    end

    // per-cycle comparison of pins against the model
    bit e_low, e_we, e_re, e_oe;
    logic [7:0] e_dq;
    always @(negedge clk) begin
        if (rst_n) begin
            e_low = (m_st == 2) && ((m_t % P) < TL);
            e_we  = !(e_low && m_op <= 2);
            e_re  = !(e_low && m_op >= 3);
            e_oe  = (m_st == 2) && m_op <= 2;
            e_dq  = !e_oe ? 8'h00 : (m_op == 0) ? m_cmd[7:0] : (m_op == 1) ? m_addr[7:0]
                                                : mem_m[m_t / P];
            check(nand_we_n == e_we, "R3 R8 R7 write strobe", nand_we_n, e_we);
            check(nand_re_n == e_re, "R9 R10 R13 read strobe", nand_re_n, e_re);
            check(nand_cle == (m_st == 2 && m_op == 0), "R3 cle", nand_cle, m_st == 2 && m_op == 0);
            check(nand_ale == (m_st == 2 && m_op == 1), "R3 ale", nand_ale, m_st == 2 && m_op == 1);
            check(nand_dq_oe == e_oe, "R6 dq_oe", nand_dq_oe, e_oe);
            check(nand_dq_o == e_dq, "R8 dq_o", nand_dq_o, e_dq);
            check(nand_ce_n == (m_ce ? ~(4'b1 << m_cs) : 4'hF), "R12 ce_n", nand_ce_n,
                  m_ce ? ~(4'b1 << m_cs) : 4'hF);
            check(irq == (m_done && !m_mask), "R5 irq", irq, m_done && !m_mask);
        end
    end

    always @(posedge clk) begin
        if (cyc == 100000) begin
            fails++; checks++;
            $display("FAIL watchdog all requirements actual=%0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string req);
        @(negedge clk); reg_addr = a; #1;
        check(reg_rdata == e, req, reg_rdata, e);
    endtask

    task automatic trig(input logic [15:0] v, input int seed);
        @(negedge clk); rd_seed = seed; rd_cnt = 0; we_cnt = 0;
        wr(3'd2, v);
    endtask

    task automatic wait_done();
        while (m_st != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic hb_chk(input int k, input logic [7:0] e, input string req);
        @(negedge clk); hb_addr = AW'(k); #1;
        check(hb_rdata == e, req, hb_rdata, e);
    endtask

    int keep;
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(3'd2, 16'h0000, "R1 ctrl");
        rd(3'd3, 16'h0010, "R1 cfg");
        rd(3'd4, 16'h0000, "R1 bsel");
        check(irq == 0 && nand_ce_n == 4'hF && nand_we_n && nand_re_n, "R1 pins",
              {irq, nand_ce_n, nand_we_n, nand_re_n}, 6'b011111);
        // R12 chip enable routing
        wr(3'd3, 16'h0080);
        wr(3'd4, 16'h0045);
        check(nand_ce_n == 4'b1011, "R12 cs2", nand_ce_n, 4'b1011);
        rd(3'd4, 16'h0045, "R12 bsel");
        wr(3'd4, 16'h0065);
        check(nand_ce_n == 4'b0111, "R12 cs3", nand_ce_n, 4'b0111);
        // R3 command cycle, R2 readback, R4 done, R5 irq
        wr(3'd0, 16'h1290);
        trig(16'h0001, 0);
        rd(3'd2, 16'h0000, "R2 op bits read 0");
        wait_done();
        rd(3'd2, 16'h8000, "R4 done set");
        check(irq == 1, "R5 irq on", irq, 1);
        check(we_cnt == 1, "R3 one pulse", we_cnt, 1);
        wr(3'd3, 16'h0090);
        check(irq == 0, "R5 masked", irq, 0);
        wr(3'd3, 16'h0080);
        wr(3'd2, 16'h8000);
        rd(3'd2, 16'h8000, "R4 sticky");
        wr(3'd2, 16'h0000);
        rd(3'd2, 16'h0000, "R4 cleared");
        // R2 lowest bit wins: bits 1 and 2 -> address cycle
        wr(3'd1, 16'h33A7);
        trig(16'h0006, 0);
        wait_done();
        check(we_cnt == 1, "R2 address only", we_cnt, 1);
        rd(3'd4, 16'h0065, "R10 addr keeps buf");
        // R7 busy wait
        nand_rb_n = 0;
        wr(3'd0, 16'h0070);
        trig(16'h0001, 0);
        repeat (12) @(negedge clk);
        check(we_cnt == 0, "R7 held while busy", we_cnt, 0);
        rd(3'd2, 16'h0000, "R7 not done");
        nand_rb_n = 1;
        wait_done();
        check(we_cnt == 1, "R7 after ready", we_cnt, 1);
        // R8 page program with R6 stray trigger
        for (int k = 0; k < LEN; k++) begin
            @(negedge clk); hb_we = 1; hb_addr = AW'(k); hb_wdata = 8'(k * 13 + 7);
        end
        @(negedge clk); hb_we = 0;
        trig(16'h0004, 0);
        repeat (10) @(negedge clk);
        wr(3'd2, 16'h0001);
        wait_done();
        check(we_cnt == LEN, "R8 R6 pulse count", we_cnt, LEN);
        rd(3'd4, 16'h0060, "R10 page clears buf");
        rd(3'd2, 16'h8000, "R8 done");
        // R9 page read
        trig(16'h0008, 1);
        wait_done();
        for (int k = 0; k < LEN; k++) hb_chk(k, fb(1, k), "R9 read byte");
        // R10 ID and status
        trig(16'h0010, 2);
        wait_done();
        for (int k = 0; k < 6; k++) hb_chk(k, fb(2, k), "R10 id byte");
        hb_chk(6, fb(1, 6), "R10 id length");
        trig(16'h0020, 3);
        wait_done();
        hb_chk(0, fb(3, 0), "R10 status byte");
        hb_chk(1, fb(2, 1), "R10 status length");
        // R11 soft reset while idle with done set
        wr(3'd3, 16'h00C0);
        #1 check(reg_rdata == 16'h00C0, "R11 bit reads 1", reg_rdata, 16'h00C0);
        rd(3'd3, 16'h0080, "R11 self clears");
        rd(3'd2, 16'h0000, "R11 done cleared");
        // R11 abort mid read, trigger in reset cycle ignored
        trig(16'h0008, 4);
        repeat (30) @(negedge clk);
        reg_we = 1; reg_addr = 3'd3; reg_wdata = 16'h00C0;
        @(negedge clk);
        check(reg_rdata == 16'h00C0, "R11 pending", reg_rdata, 16'h00C0);
        reg_addr = 3'd2; reg_wdata = 16'h0001;
        @(negedge clk); reg_we = 0;
        keep = rd_cnt;
        repeat (20) @(negedge clk);
        check(rd_cnt == keep && we_cnt == 0, "R11 abort quiet", rd_cnt, keep);
        rd(3'd2, 16'h0000, "R11 no done");
        trig(16'h0020, 5);
        wait_done();
        rd(3'd2, 16'h8000, "R11 recovers");
        hb_chk(0, fb(5, 0), "R11 status after");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule